// File: doc/BRIEF.md
# One-Time-Programmable Word Memory Model

This block is a synthesizable, clocked model of a 16-bit-wide programmable read-only memory whose bits can only be cleared by programming and restored by a bulk erase. It takes an active-low chip select, an active-low output enable, a flag for the raised programming voltage and a flag for the raised voltage on address line 9. It returns a 16-bit data word together with a drive-enable indication, which stands in for a tri-state bus. Read, output disable, standby, program, program inhibit, verify and identifier readout are all modelled. A synchronous erase-all input stands in for ultraviolet erasure.

Access time is modelled as a fixed number of clock edges that chip select must be seen low before data is driven. When chip select rises, the access count is cleared. A word is programmed once on each falling edge of chip select when the programming voltage is present and output enable is high. The incoming word is ANDed into the stored word. When the address line 9 high-voltage flag is set and every address bit other than bits 0 and 9 is zero, the data path returns a two-word identifier selected by address bit 0.

Top module: `otp_word_mem`

## Requirements
- R1: While chip select is high, dout_en_o is 0, whatever the output enable does. Whenever dout_en_o is 0, dout_o is 0x0000.
- R2: With chip select low and output enable high, dout_en_o is 0 and dout_o is 0x0000.
- R3: dout_en_o rises only after chip select has been sampled low on ACCESS_LAT consecutive rising clock edges while output enable is low. A single edge with chip select high restarts that count.
- R4: After reset, and one edge after erase_i is sampled high, every word reads 0xFFFF.
- R5: A program takes place on the edge where chip select is first sampled low after being high, with vpp_on_i = 1 and oe_n_i = 1. The stored word becomes old AND din_i, so a 1 in din_i leaves the stored bit unchanged.
- R6: With vpp_on_i = 1 and chip select held high, no word changes, whatever data and address are applied.
- R7: With id_hv_i = 1 and every address bit except bits 0 and 9 zero, a read returns 0x0020 for addr_i[0] = 0 and 0x0034 for addr_i[0] = 1. Bits 15 to 8 are always zero.
- R8: With id_hv_i = 1 and any other address bit set, a read returns the array word at that address.
- R9: A read with vpp_on_i = 1, oe_n_i = 0 and chip select low is a verify. It returns the stored word and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the access pipe and sets all words to 0xFFFF |
| erase_i | input | 1 | Synchronous erase of all words to 0xFFFF |
| sel_n_i | input | 1 | Active-low chip select |
| oe_n_i | input | 1 | Active-low output enable |
| vpp_on_i | input | 1 | Programming voltage present |
| id_hv_i | input | 1 | High voltage present on address line 9 |
| addr_i | input | ADDR_W | Word address |
| din_i | input | 16 | Word to program |
| dout_o | output | 16 | Read data, 0 when not driven |
| dout_en_o | output | 1 | Data bus driven |

## Verification
The bench builds the block with ADDR_W = 10 and ACCESS_LAT = 3. Ten address bits make address line 9 exist, so the identifier decode can be reached both at 0x200/0x201 and at a near-miss address such as 0x203. They also let the top word 0x3FF be programmed. A latency of three leaves room to observe the output still off one edge before the access completes. It also lets a two-edge low, one-edge high, two-edge low pattern show that the count restarts.

// File: rtl/otp_word_mem_pkg.sv
package otp_word_mem_pkg;
  localparam int unsigned WORD_W = 16;
  localparam logic [WORD_W-1:0] ID_MAKER = 16'h0020;
  localparam logic [WORD_W-1:0] ID_PART  = 16'h0034;

  // Programming can only clear bits.
  function automatic logic [WORD_W-1:0] merge_word(input logic [WORD_W-1:0] stored,
                                                   input logic [WORD_W-1:0] incoming);
    return stored & incoming;
  endfunction

  function automatic logic [WORD_W-1:0] id_word(input logic sel_hi);
    return sel_hi ? ID_PART : ID_MAKER;
  endfunction
endpackage

// File: rtl/otp_cell_array.sv
module otp_cell_array
  import otp_word_mem_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (erase_i) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (we_i) begin
      cells[addr_i] <= merge_word(cells[addr_i], wdata_i);
    end
  end

  assign rdata_o = cells[addr_i];

  // R4: erase restores ones at both ends of the array
  assert_erase_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
    erase_i |=> ((&cells[0]) && (&cells[DEPTH-1])));

  // R5: every zero in the programmed word is stored as zero
  assert_prog_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !erase_i) |=> ((cells[$past(addr_i)] & ~$past(wdata_i)) == '0));

  // R5: programming never raises a bit
  assert_prog_no_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !erase_i) |=> ((cells[$past(addr_i)] & ~$past(cells[addr_i])) == '0));
endmodule

// File: rtl/otp_access_pipe.sv
module otp_access_pipe #(
  parameter int unsigned ACCESS_LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n_i,
  output logic ready_o,
  output logic fall_o
);
  localparam int unsigned CNT_W = $clog2(ACCESS_LAT + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(ACCESS_LAT);

  logic [CNT_W-1:0] cnt_q;
  logic             sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sel_q <= 1'b1;
    end else begin
      sel_q <= sel_n_i;
      if (sel_n_i)              cnt_q <= '0;
      else if (cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ready_o = (cnt_q == CNT_TOP);
  assign fall_o  = sel_q & ~sel_n_i;

  // R3: the access cannot be complete one edge after select was high
  assert_ready_after_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> !$past(sel_n_i));
endmodule

// File: rtl/otp_id_decode.sv
module otp_id_decode
  import otp_word_mem_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              hv_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [WORD_W-1:0] id_o
);
  localparam logic [ADDR_W-1:0] PASS_MASK = ADDR_W'(1) | (ADDR_W'(1) << 9);

  assign hit_o = hv_i && ((addr_i & ~PASS_MASK) == '0);
  assign id_o  = id_word(addr_i[0]);
endmodule

// File: rtl/otp_word_mem.sv
module otp_word_mem
  import otp_word_mem_pkg::*;
#(
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned ACCESS_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase_i,
  input  logic              sel_n_i,
  input  logic              oe_n_i,
  input  logic              vpp_on_i,
  input  logic              id_hv_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       din_i,
  output logic [15:0]       dout_o,
  output logic              dout_en_o
);
  logic              access_ready;
  logic              sel_fall;
  logic              prog_fire;
  logic              id_hit;
  logic [WORD_W-1:0] id_data;
  logic [WORD_W-1:0] array_data;

  otp_access_pipe #(.ACCESS_LAT(ACCESS_LAT)) pipe_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_n_i (sel_n_i),
    .ready_o (access_ready),
    .fall_o  (sel_fall)
  );

  assign prog_fire = sel_fall & vpp_on_i & oe_n_i;

  otp_cell_array #(.ADDR_W(ADDR_W)) array_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .erase_i (erase_i),
    .we_i    (prog_fire),
    .addr_i  (addr_i),
    .wdata_i (din_i),
    .rdata_o (array_data)
  );

  otp_id_decode #(.ADDR_W(ADDR_W)) id_i (
    .hv_i   (id_hv_i),
    .addr_i (addr_i),
    .hit_o  (id_hit),
    .id_o   (id_data)
  );

  assign dout_en_o = access_ready & ~sel_n_i & ~oe_n_i;
  assign dout_o    = dout_en_o ? (id_hit ? id_data : array_data) : '0;

  // R1: standby keeps the bus released
  assert_standby_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n_i |-> !dout_en_o);

  // R1: undriven bus reads as zero
  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en_o |-> (dout_o == '0));

  // R2: output disable
  assert_oe_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n_i && oe_n_i) |-> !dout_en_o);

  // R6: program inhibit while select is held high
  assert_inhibit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vpp_on_i && sel_n_i) |-> !prog_fire);

  // R7: identifier words only
  assert_id_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (id_hit && dout_en_o) |-> ((dout_o[15:8] == 8'h00) &&
                               (dout_o == 16'h0020 || dout_o == 16'h0034)));

  // R9: a verify never writes
  assert_verify_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n_i |-> !prog_fire);
endmodule

// File: tb/otp_word_mem_tb.sv
module otp_word_mem_tb_top;
  localparam int unsigned AW  = 10;
  localparam int unsigned LAT = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          erase_i = 1'b0;
  logic          sel_n_i = 1'b1;
  logic          oe_n_i = 1'b1;
  logic          vpp_on_i = 1'b0;
  logic          id_hv_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [15:0]   din_i = '0;
  logic [15:0]   dout_o;
  logic          dout_en_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  otp_word_mem #(.ADDR_W(AW), .ACCESS_LAT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .erase_i(erase_i), .sel_n_i(sel_n_i),
    .oe_n_i(oe_n_i), .vpp_on_i(vpp_on_i), .id_hv_i(id_hv_i),
    .addr_i(addr_i), .din_i(din_i), .dout_o(dout_o), .dout_en_o(dout_en_o)
  );

  // op[43:42] 0=program 1=read 2=read with id_hv; addr[41:32]; data[31:16]; expect[15:0]
  localparam int NV = 14;
  localparam logic [43:0] VEC [NV] = '{
    {2'd0, 10'h005, 16'h0F0F, 16'h0000},
    {2'd1, 10'h005, 16'h0000, 16'h0F0F},  // R5
    {2'd0, 10'h005, 16'hFF00, 16'h0000},
    {2'd1, 10'h005, 16'h0000, 16'h0F00},  // R5 merge
    {2'd0, 10'h005, 16'hFFFF, 16'h0000},
    {2'd1, 10'h005, 16'h0000, 16'h0F00},  // R5 ones keep
    {2'd1, 10'h006, 16'h0000, 16'hFFFF},  // R4
    {2'd0, 10'h3FF, 16'h1234, 16'h0000},
    {2'd1, 10'h3FF, 16'h0000, 16'h1234},  // R5 top word
    {2'd0, 10'h201, 16'hABCD, 16'h0000},
    {2'd2, 10'h200, 16'h0000, 16'h0020},  // R7
    {2'd2, 10'h201, 16'h0000, 16'h0034},  // R7
    {2'd1, 10'h201, 16'h0000, 16'hABCD},  // R8 array path without flag
    {2'd2, 10'h203, 16'h0000, 16'hFFFF}   // R8 other bit set
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    sel_n_i = 1'b1; oe_n_i = 1'b1; vpp_on_i = 1'b1; addr_i = a; din_i = d;
    @(negedge clk);
    sel_n_i = 1'b0;
    @(negedge clk);
    sel_n_i = 1'b1;
    @(negedge clk);
    vpp_on_i = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic hv, input logic vpp,
                    output logic [15:0] val, output logic en);
    @(negedge clk);
    addr_i = a; id_hv_i = hv; vpp_on_i = vpp; oe_n_i = 1'b0; sel_n_i = 1'b0;
    repeat (LAT) @(posedge clk);
    @(negedge clk);
    val = dout_o; en = dout_en_o;
    sel_n_i = 1'b1; oe_n_i = 1'b1; id_hv_i = 1'b0; vpp_on_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic e;
    repeat (3) @(negedge clk);
    chk("R1 reset en", {15'd0, dout_en_o}, 16'd0);
    chk("R1 reset data", dout_o, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    rd(10'h005, 1'b0, 1'b0, v, e);
    chk("R4 after reset", v, 16'hFFFF);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k][43:42] == 2'd0) begin
        prog(VEC[k][41:32], VEC[k][31:16]);
      end else begin
        rd(VEC[k][41:32], VEC[k][43:42] == 2'd2, 1'b0, v, e);
        chk($sformatf("R5/R7/R8 vector %0d", k), v, VEC[k][15:0]);
      end
    end

    // R3: not ready after LAT-1 edges, ready after LAT
    @(negedge clk);
    addr_i = 10'h005; oe_n_i = 1'b0; sel_n_i = 1'b0;
    repeat (LAT - 1) @(posedge clk);
    @(negedge clk);
    chk("R3 early", {15'd0, dout_en_o}, 16'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R3 on time", {15'd0, dout_en_o}, 16'd1);
    chk("R3 data", dout_o, 16'h0F00);

    // R2: output enable high while selected
    oe_n_i = 1'b1;
    #1;
    chk("R2 en", {15'd0, dout_en_o}, 16'd0);
    chk("R2 data", dout_o, 16'h0000);

    // R1: standby with output enable low
    @(negedge clk);
    oe_n_i = 1'b0; sel_n_i = 1'b1;
    #1;
    chk("R1 standby en", {15'd0, dout_en_o}, 16'd0);

    // R3: one high edge restarts the count
    @(negedge clk);
    sel_n_i = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    sel_n_i = 1'b1;
    @(negedge clk);
    sel_n_i = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R3 restart", {15'd0, dout_en_o}, 16'd0);
    sel_n_i = 1'b1; oe_n_i = 1'b1;
    @(negedge clk);

    // R6: inhibit with select held high
    vpp_on_i = 1'b1; addr_i = 10'h007; din_i = 16'h0000;
    repeat (4) @(negedge clk);
    vpp_on_i = 1'b0;
    rd(10'h007, 1'b0, 1'b0, v, e);
    chk("R6 inhibit", v, 16'hFFFF);

    // R9: verify reads the stored word and writes nothing
    din_i = 16'h0000;
    rd(10'h3FF, 1'b0, 1'b1, v, e);
    chk("R9 verify data", v, 16'h1234);
    chk("R9 verify en", {15'd0, e}, 16'd1);
    rd(10'h3FF, 1'b0, 1'b0, v, e);
    chk("R9 no write", v, 16'h1234);

    // R4: erase all
    @(negedge clk);
    erase_i = 1'b1;
    @(negedge clk);
    erase_i = 1'b0;
    rd(10'h005, 1'b0, 1'b0, v, e);
    chk("R4 erase 005", v, 16'hFFFF);
    rd(10'h3FF, 1'b0, 1'b0, v, e);
    chk("R4 erase 3FF", v, 16'hFFFF);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule